// File: doc/BRIEF.md
# Coprocessor Pipeline Follower

This block lets a coprocessor keep step with the instruction pipeline of a host processor. It has no fetch of its own. Whenever the host requests memory, the block captures the 32-bit word on the host instruction bus into a Decode stage. From there the word moves through Execute and Memory. Every stage moves only on a clock edge at which the host's shared clock enable is high. Along with each instruction the block captures the host's privilege level and its two instruction-set state bits. These travel down the pipeline with the instruction. The block answers the host with a 2-bit handshake code from Decode and another from Execute.

The block recognises three operations for its own coprocessor number:
- a move from the host into a coprocessor register, taking the value from the write data bus;
- a move from a coprocessor register to the host, driven on the read data bus during the Memory stage;
- a register-to-register add.

Register writes are committed at the end of the Memory stage. This lets a late cancel in that cycle suppress the write without any rollback storage. An instruction that the host does not pass out of Execute is dropped. A static presence input keeps the block idle when no coprocessor is fitted.

Top module: `cp_follower`

## Requirements
- R1: After reset both handshake outputs are 2'b00, the read data bus is zero and every coprocessor register reads zero.
- R2: While the clock enable is low, no stage advances and no register is written, so both handshake codes hold their values.
- R3: Decode loads the instruction bus only on an edge where the clock enable is high, the active-low request is low and the presence input is high. Any other advancing edge leaves a bubble, and the Decode code becomes 2'b00.
- R4: The Decode code is 2'b10 (go) for a valid instruction that meets all four of these conditions, and 2'b00 (absent) otherwise:
  - bits [11:8] equal the coprocessor number (default 7);
  - bits [23:20] are 1 (move in), 2 (move out) or 3 (add);
  - both instruction-set state bits were 0 at capture;
  - the privilege rule of R6 allows it.
- R5: The Execute code is 2'b11 (last) for a move in or move out, 2'b10 (go) for an add, and 2'b00 for an empty or unrecognised Execute stage. Code 2'b01 (wait) is reserved.
- R6: Register 7 is privileged. An instruction that names it in a field it uses (destination bits [14:12], source bits [18:16], second source bits [2:0]) is answered 2'b00 in both stages and has no effect when it was captured in user mode (privilege bit 0).
- R7: An instruction in Execute moves on to Memory only if the pass input is high on the advancing edge. Otherwise it is discarded with no register write and no read data.
- R8: A move in writes the write data bus, sampled on the edge that ends its Memory cycle, into the destination register.
- R9: During a move out's Memory cycle the read data bus shows the source register. At all other times it is zero.
- R10: An add writes source plus second source (modulo 2^32) into the destination at the end of its Memory cycle. A result written by the instruction just ahead is already seen.
- R11: A late cancel that is high on the edge ending an instruction's Memory cycle suppresses that instruction's register write.
- R12: When the presence input is low, no instruction is loaded and both codes stay 2'b00.
- R13: The privilege and state bits are those captured with the instruction. Changing the inputs after capture does not alter that instruction's handling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Shared pipeline advance enable from the host |
| mreq_n | input | 1 | Active-low request; low loads the instruction bus into Decode |
| present | input | 1 | Static tie-off; high when a coprocessor is fitted |
| instr_in | input | 32 | Host instruction bus |
| priv_in | input | 1 | Host privilege: 0 user, 1 privileged |
| isa_in | input | 2 | Host instruction-set state bits; 0 means the base set |
| pass_in | input | 1 | Host confirms the Execute instruction must execute |
| late_cancel_in | input | 1 | Abandon the instruction in its Memory cycle |
| wdata_in | input | 32 | Data from host to coprocessor |
| rdata_out | output | 32 | Data from coprocessor to host |
| hs_dec_out | output | 2 | Handshake code from the Decode stage |
| hs_exe_out | output | 2 | Handshake code from the Execute stage |

## Verification
Counting from the edge that captures an instruction:
- the Decode code is valid right after that edge;
- the Execute code is valid after the next enabled edge;
- the read data appears after the edge that moves the instruction into Memory;
- a write lands on the edge after that.

Each scenario task drives its inputs at the falling edge and steps one enabled edge at a time. It compares the output due in that cycle before the next rising edge. Register contents are confirmed later through a move out, whose read data is compared in its own Memory cycle. Stall cycles are counted explicitly so that each expected value keeps its place.

// File: rtl/cpf_pkg.sv
// Package: shared types and the handshake rule for the coprocessor follower.
// Assumes a 32-bit instruction word.
package cpf_pkg;
    localparam int INSTR_W = 32;

    typedef enum logic [1:0] {
        HS_ABSENT = 2'b00,
        HS_WAIT   = 2'b01,
        HS_GO     = 2'b10,
        HS_LAST   = 2'b11
    } hs_e;

    typedef enum logic [1:0] {
        OP_NONE = 2'd0,
        OP_MIN  = 2'd1,
        OP_MOUT = 2'd2,
        OP_ADD  = 2'd3
    } op_e;

    typedef struct packed {
        logic               valid;
        logic [INSTR_W-1:0] instr;
        logic               priv;
        logic [1:0]         isa;
        op_e                op;
    } stage_t;

    // Execute-stage code for a decoded operation.
    function automatic hs_e exe_code(input logic valid, input op_e op);
        if (!valid) return HS_ABSENT;
        case (op)
            OP_MIN, OP_MOUT: return HS_LAST;
            OP_ADD:          return HS_GO;
            default:         return HS_ABSENT;
        endcase
    endfunction
endpackage

// File: rtl/cpf_decode.sv
// Module: cpf_decode
// Classifies the Decode-stage word into an operation, or OP_NONE when the
// word is not for this coprocessor, is in a non-base instruction set, or
// touches the privileged register from user mode.
// Assumes a register count that is a power of two; the top register is privileged.
module cpf_decode
    import cpf_pkg::*;
#(
    parameter logic [3:0] CP_NUM = 4'd7,
    parameter int         NREG   = 8
) (
    input  stage_t stg,
    output op_e    op
);
    localparam int IDXW = $clog2(NREG);
    localparam logic [IDXW-1:0] PRIV_REG = IDXW'(NREG - 1);

    logic [IDXW-1:0] rd, rn, rm;
    logic [3:0]      opf;
    op_e             raw;
    logic            priv_hit;

    // Pick out the fields and the raw operation.
    always_comb begin
        rd  = stg.instr[12 +: IDXW];
        rn  = stg.instr[16 +: IDXW];
        rm  = stg.instr[0  +: IDXW];
        opf = stg.instr[23:20];
        case (opf)
            4'd1:    raw = OP_MIN;
            4'd2:    raw = OP_MOUT;
            4'd3:    raw = OP_ADD;
            default: raw = OP_NONE;
        endcase
    end

    // Privileged register use, counting only the fields the operation reads or writes.
    always_comb begin
        case (raw)
            OP_MIN:  priv_hit = (rd == PRIV_REG);
            OP_MOUT: priv_hit = (rn == PRIV_REG);
            OP_ADD:  priv_hit = (rd == PRIV_REG) || (rn == PRIV_REG) || (rm == PRIV_REG);
            default: priv_hit = 1'b0;
        endcase
    end

    // Final classification.
    always_comb begin
        if (!stg.valid || stg.instr[11:8] != CP_NUM || stg.isa != 2'b00 ||
            (priv_hit && !stg.priv))
            op = OP_NONE;
        else
            op = raw;
    end
endmodule

// File: rtl/cpf_stages.sv
// Module: cpf_stages
// Decode, Execute and Memory registers. All three advance only on an
// enabled edge. Decode loads on a request, Execute takes the decoded
// operation, and Memory takes only passed, recognised work.
// Assumes the host holds pass_in valid on the edge that leaves Execute.
module cpf_stages
    import cpf_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                mreq_n,
    input  logic                present,
    input  logic [INSTR_W-1:0]  instr_in,
    input  logic                priv_in,
    input  logic [1:0]          isa_in,
    input  logic                pass_in,
    input  op_e                 dec_op,
    output stage_t              d_q,
    output stage_t              e_q,
    output stage_t              m_q
);
    // Decode register: capture the bus and mode bits on a request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            d_q <= '0;
        end else if (clk_en) begin
            d_q.valid <= present && !mreq_n;
            d_q.instr <= instr_in;
            d_q.priv  <= priv_in;
            d_q.isa   <= isa_in;
            d_q.op    <= OP_NONE;
        end
    end

    // Execute register: carry the word with its decoded operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e_q <= '0;
        end else if (clk_en) begin
            e_q    <= d_q;
            e_q.op <= d_q.valid ? dec_op : OP_NONE;
        end
    end

    // Memory register: keep only passed, recognised instructions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            m_q <= '0;
        end else if (clk_en) begin
            m_q       <= e_q;
            m_q.valid <= e_q.valid && pass_in && (e_q.op != OP_NONE);
        end
    end

    // R2
    // stall_hold_chk
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(d_q) && $stable(e_q) && $stable(m_q));

    // R3
    // bubble_chk
    bubble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && (mreq_n || !present) |=> !d_q.valid);

    // R7
    // pass_drop_chk
    pass_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && !pass_in |=> !m_q.valid);
endmodule

// File: rtl/cpf_regfile.sv
// Module: cpf_regfile
// Small register file. Reads happen combinationally in the Memory stage;
// writes commit on the enabled edge that ends the Memory cycle unless late
// cancel is high then.
// Assumes at most one Memory-stage instruction per cycle.
module cpf_regfile
    import cpf_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clk_en,
    input  logic                late_cancel,
    input  stage_t              m_q,
    input  logic [INSTR_W-1:0]  wdata,
    output logic [INSTR_W-1:0]  rdata
);
    localparam int IDXW = $clog2(NREG);

    logic [NREG-1:0][INSTR_W-1:0] regs;
    logic [IDXW-1:0]              rd, rn, rm;
    logic                         wr_en;
    logic [INSTR_W-1:0]           wr_val;

    // Operand selection and write value for the Memory instruction.
    always_comb begin
        rd     = m_q.instr[12 +: IDXW];
        rn     = m_q.instr[16 +: IDXW];
        rm     = m_q.instr[0  +: IDXW];
        wr_en  = clk_en && m_q.valid && !late_cancel &&
                 (m_q.op == OP_MIN || m_q.op == OP_ADD);
        wr_val = (m_q.op == OP_ADD) ? regs[rn] + regs[rm] : wdata;
        rdata  = (m_q.valid && m_q.op == OP_MOUT) ? regs[rn] : '0;
    end

    // Commit the write at the end of the Memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)
            regs <= '0;
        else if (wr_en)
            regs[rd] <= wr_val;
    end

    // R11
    // cancel_hold_chk
    cancel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && late_cancel |=> $stable(regs));

    // R2
    // stall_regs_chk
    stall_regs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> $stable(regs));
endmodule

// File: rtl/cp_follower.sv
// Module: cp_follower (top)
// Follows the host pipeline for one coprocessor and answers the host with
// handshake codes from Decode and Execute.
// Assumes late cancel is raised only in the cycle after a data abort.
module cp_follower
    import cpf_pkg::*;
#(
    parameter logic [3:0] CP_NUM = 4'd7,
    parameter int         NREG   = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        clk_en,
    input  logic        mreq_n,
    input  logic        present,
    input  logic [31:0] instr_in,
    input  logic        priv_in,
    input  logic [1:0]  isa_in,
    input  logic        pass_in,
    input  logic        late_cancel_in,
    input  logic [31:0] wdata_in,
    output logic [31:0] rdata_out,
    output logic [1:0]  hs_dec_out,
    output logic [1:0]  hs_exe_out
);
    stage_t d_q, e_q, m_q;
    op_e    dec_op;

    cpf_decode #(.CP_NUM(CP_NUM), .NREG(NREG)) u_decode (
        .stg (d_q),
        .op  (dec_op)
    );

    cpf_stages u_stages (
        .clk      (clk),
        .rst_n    (rst_n),
        .clk_en   (clk_en),
        .mreq_n   (mreq_n),
        .present  (present),
        .instr_in (instr_in),
        .priv_in  (priv_in),
        .isa_in   (isa_in),
        .pass_in  (pass_in),
        .dec_op   (dec_op),
        .d_q      (d_q),
        .e_q      (e_q),
        .m_q      (m_q)
    );

    cpf_regfile #(.NREG(NREG)) u_regfile (
        .clk         (clk),
        .rst_n       (rst_n),
        .clk_en      (clk_en),
        .late_cancel (late_cancel_in),
        .m_q         (m_q),
        .wdata       (wdata_in),
        .rdata       (rdata_out)
    );

    // Handshake codes from the two stages.
    always_comb begin
        hs_dec_out = (d_q.valid && dec_op != OP_NONE) ? HS_GO : HS_ABSENT;
        hs_exe_out = exe_code(e_q.valid, e_q.op);
    end

    // R9
    // rdata_idle_chk
    rdata_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clk_en && !pass_in |=> rdata_out == '0);

    // R12
    // absent_chk
    absent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !present && clk_en |=> hs_dec_out == HS_ABSENT);
endmodule

// File: tb/cp_follower_bench.sv
// Directed bench for cp_follower: one task per scenario, each checking itself.
module cp_follower_bench;
    logic        clk = 1'b0;
    logic        rst_n, clk_en, mreq_n, present, priv_in, pass_in, late_cancel_in;
    logic [1:0]  isa_in;
    logic [31:0] instr_in, wdata_in;
    logic [31:0] rdata_out;
    logic [1:0]  hs_dec_out, hs_exe_out;

    int n_chk = 0;
    int n_fail = 0;
    logic [31:0] model [8];

    always #5 clk = ~clk;

    cp_follower u_cp_follower (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .mreq_n(mreq_n),
        .present(present), .instr_in(instr_in), .priv_in(priv_in),
        .isa_in(isa_in), .pass_in(pass_in), .late_cancel_in(late_cancel_in),
        .wdata_in(wdata_in), .rdata_out(rdata_out),
        .hs_dec_out(hs_dec_out), .hs_exe_out(hs_exe_out)
    );

    function automatic logic [31:0] mk(input logic [3:0] op, input int rd,
                                       input int rn, input int rm,
                                       input logic [3:0] cpn = 4'd7);
        return {8'hEE, op, 1'b0, rn[2:0], 1'b0, rd[2:0], cpn, 5'b0, rm[2:0]};
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    // One isolated instruction through all stages; priv_in flips after capture (R13).
    task automatic run_op(input logic [31:0] ins, input logic priv, input logic [1:0] isa,
                          input logic pass, input logic lc, input logic [31:0] wd,
                          input logic [1:0] exp_dec, input logic [1:0] exp_exe,
                          input logic [31:0] exp_rd, input string tag);
        mreq_n = 1'b0; instr_in = ins; priv_in = priv; isa_in = isa;
        tick();
        chk(32'(hs_dec_out), 32'(exp_dec), {tag, " R4 dec"});
        mreq_n = 1'b1; priv_in = ~priv; isa_in = 2'b00; instr_in = mk(4'd1, 0, 0, 0);
        tick();
        chk(32'(hs_exe_out), 32'(exp_exe), {tag, " R5 exe"});
        pass_in = pass;
        tick();
        pass_in = 1'b0;
        chk(rdata_out, exp_rd, {tag, " R9 rdata"});
        wdata_in = wd; late_cancel_in = lc;
        tick();
        late_cancel_in = 1'b0;
    endtask

    task automatic read_reg(input int idx, input string tag);
        run_op(mk(4'd2, 0, idx, 0), 1'b1, 2'b00, 1'b1, 1'b0, 32'h0,
               2'b10, 2'b11, model[idx], tag);
    endtask

    task automatic t_reset();
        chk(32'(hs_dec_out), 32'h0, "R1 dec code");
        chk(32'(hs_exe_out), 32'h0, "R1 exe code");
        chk(rdata_out, 32'h0, "R1 rdata");
        read_reg(5, "R1 reg5 zero");
    endtask

    task automatic t_move_add();
        run_op(mk(4'd1, 1, 0, 0), 1'b0, 2'b00, 1'b1, 1'b0, 32'hDEAD_0001,
               2'b10, 2'b11, 32'h0, "R8 move in r1");
        model[1] = 32'hDEAD_0001;
        read_reg(1, "R8 r1 readback");
        run_op(mk(4'd1, 2, 0, 0), 1'b0, 2'b00, 1'b1, 1'b0, 32'hFFFF_FFFF,
               2'b10, 2'b11, 32'h0, "R8 move in r2");
        model[2] = 32'hFFFF_FFFF;
        run_op(mk(4'd3, 3, 1, 2), 1'b0, 2'b00, 1'b1, 1'b0, 32'h0,
               2'b10, 2'b10, 32'h0, "R10 add");
        model[3] = model[1] + model[2];
        read_reg(3, "R10 sum wraps");
    endtask

    task automatic t_pass_cancel();
        run_op(mk(4'd1, 4, 0, 0), 1'b0, 2'b00, 1'b0, 1'b0, 32'h1234_5678,
               2'b10, 2'b11, 32'h0, "R7 not passed");
        read_reg(4, "R7 r4 untouched");
        run_op(mk(4'd2, 0, 1, 0), 1'b0, 2'b00, 1'b0, 1'b0, 32'h0,
               2'b10, 2'b11, 32'h0, "R7 move out dropped");
        run_op(mk(4'd1, 1, 0, 0), 1'b0, 2'b00, 1'b1, 1'b1, 32'h5555_5555,
               2'b10, 2'b11, 32'h0, "R11 cancelled");
        read_reg(1, "R11 r1 kept");
    endtask

    task automatic t_reject();
        run_op(mk(4'd1, 5, 0, 0, 4'd3), 1'b0, 2'b00, 1'b1, 1'b0, 32'h77,
               2'b00, 2'b00, 32'h0, "R4 other cp");
        run_op(mk(4'd9, 5, 0, 0), 1'b0, 2'b00, 1'b1, 1'b0, 32'h77,
               2'b00, 2'b00, 32'h0, "R4 bad op");
        run_op(mk(4'd1, 5, 0, 0), 1'b0, 2'b01, 1'b1, 1'b0, 32'h77,
               2'b00, 2'b00, 32'h0, "R4 alt isa");
        run_op(mk(4'd1, 7, 0, 0), 1'b0, 2'b00, 1'b1, 1'b0, 32'h77,
               2'b00, 2'b00, 32'h0, "R6 user r7");
        read_reg(5, "R4 r5 untouched");
        read_reg(7, "R6 r7 untouched");
        run_op(mk(4'd1, 7, 0, 0), 1'b1, 2'b00, 1'b1, 1'b0, 32'hC0DE_0007,
               2'b10, 2'b11, 32'h0, "R13 priv r7 after flip");
        model[7] = 32'hC0DE_0007;
        read_reg(7, "R13 r7 written");
    endtask

    task automatic t_bubble_present();
        mreq_n = 1'b1; instr_in = mk(4'd1, 5, 0, 0);
        tick();
        chk(32'(hs_dec_out), 32'h0, "R3 bubble");
        present = 1'b0; mreq_n = 1'b0;
        tick();
        chk(32'(hs_dec_out), 32'h0, "R12 absent dec");
        mreq_n = 1'b1;
        tick();
        chk(32'(hs_exe_out), 32'h0, "R12 absent exe");
        present = 1'b1;
    endtask

    task automatic t_stall();
        mreq_n = 1'b0; instr_in = mk(4'd1, 6, 0, 0);
        tick();
        clk_en = 1'b0; instr_in = mk(4'd1, 5, 0, 0, 4'd2);
        for (int i = 0; i < 3; i++) tick();
        chk(32'(hs_dec_out), 32'h2, "R2 dec held");
        chk(32'(hs_exe_out), 32'h0, "R2 exe held");
        clk_en = 1'b1; mreq_n = 1'b1;
        tick();
        chk(32'(hs_exe_out), 32'h3, "R2 exe after resume");
        pass_in = 1'b1;
        tick();
        pass_in = 1'b0; clk_en = 1'b0; wdata_in = 32'hBAD0_BAD0;
        for (int i = 0; i < 2; i++) tick();
        clk_en = 1'b1; wdata_in = 32'h6666_0006;
        tick();
        model[6] = 32'h6666_0006;
        read_reg(6, "R2 write on enabled edge");
    endtask

    task automatic t_back_to_back();
        pass_in = 1'b1; mreq_n = 1'b0; instr_in = mk(4'd1, 1, 0, 0);
        tick();
        instr_in = mk(4'd3, 3, 1, 1);
        tick();
        mreq_n = 1'b1;
        tick();
        wdata_in = 32'h0000_0005;
        tick();
        tick();
        pass_in = 1'b0;
        model[1] = 32'h5; model[3] = 32'hA;
        tick();
        read_reg(3, "R10 back to back");
    endtask

    initial begin
        for (int i = 0; i < 8; i++) model[i] = '0;
        rst_n = 1'b0; clk_en = 1'b1; mreq_n = 1'b1; present = 1'b1;
        instr_in = '0; priv_in = 1'b0; isa_in = 2'b00; pass_in = 1'b0;
        late_cancel_in = 1'b0; wdata_in = '0;
        @(negedge clk); tick(); tick();
        rst_n = 1'b1;
        t_reset();
        t_move_add();
        t_pass_cancel();
        t_reject();
        t_bubble_present();
        t_stall();
        t_back_to_back();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule